// File: doc/BRIEF.md
# Power-Stage Startup Sequencer

This block sits on the controller side of an inverter power stage. It decides when the PWM commands reach the gate drivers. After a start request it waits until three supply and relay signals are good together. It then drives a timed reset pulse into the stage's fault latch. Next it runs a priming phase in which every lower switch is held on and every upper switch is held off, so the floating bootstrap capacitors can charge. Only after that do the normal PWM commands pass through.

While the stage is switching, loss of the precharge relay feedback blocks PWM in the same cycle. The sequencer then falls back to waiting for good conditions, and it must issue a new reset pulse before it enables PWM again.

A stop request starts an orderly shutdown. The block first asks the speed loop to ramp to zero, with PWM still running. Once the speed is reported as zero, it inhibits PWM and raises a request to disconnect the mains. The state is always visible as a 3-bit code.

Top module: `pstage_seq`

## Requirements
- R1: While `rst_n` is low, `state_code` is 0 (idle) and `pwm_en`, `drv_reset`, `prime_req`, `ramp_req`, `mains_off_req`, `pwm_hi_out` and `pwm_lo_out` are all low.
- R2: In idle (code 0) the block stays put, even when all supply conditions are good, until `start_req` is sampled high. It then moves to the waiting state (code 1) on the next clock edge.
- R3: From code 1 the block advances to the reset-pulse state (code 2) only when `supply_ok`=1, `uv_fb`=0 and `relay_fb`=1 hold together. The three inputs pass through a `SYNC_STAGES`-flop synchronizer (default 2), so the state changes on the third rising edge after the inputs settle.
- R4: `drv_reset` is high only in code 2 and stays high for exactly `RST_US*CYC_PER_US` clock cycles. `pwm_en` stays low throughout.
- R5: If any of the three start conditions fails while in code 1 or code 2, the block returns to or stays in code 1, and `pwm_en` never rises.
- R6: After the reset pulse the block is in the priming state (code 3) for exactly `PRIME_US*CYC_PER_US` cycles. During priming `prime_req` is high, all bits of `pwm_hi_out` are 0 and all bits of `pwm_lo_out` are 1, whatever the PWM inputs are.
- R7: In the run state (code 4) `pwm_en` is high and `pwm_hi_out`/`pwm_lo_out` equal `pwm_hi_in`/`pwm_lo_in` bit for bit.
- R8: When the raw `relay_fb` is low, `pwm_en` and every PWM output are low in the same cycle, with no clock edge needed. From codes 3, 4 or 5 the block then returns to code 1.
- R9: After a relay-feedback drop, PWM is enabled again only after a fresh full-width reset pulse and a fresh full priming phase.
- R10: `start_req` high in code 4 moves nothing. `stop_req` high in code 4 moves the block to the ramp-down state (code 5) on the next edge. There `ramp_req` is high and the PWM commands still pass through.
- R11: `speed_zero` high in code 5 moves the block to the off state (code 6). There `pwm_en` and all PWM outputs are low and `mains_off_req` is high, and the block stays in code 6 whatever the inputs do, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| supply_ok | input | 1 | External 15 V control supply is good |
| uv_fb | input | 1 | Gate-drive supply undervoltage feedback, high = undervoltage |
| relay_fb | input | 1 | Precharge relay energised feedback, high = bypassed |
| start_req | input | 1 | Request to bring the stage up |
| stop_req | input | 1 | Request for an orderly shutdown |
| speed_zero | input | 1 | Speed loop reports zero speed |
| pwm_hi_in | input | LEGS | Upper-switch commands from the modulator |
| pwm_lo_in | input | LEGS | Lower-switch commands from the modulator |
| pwm_hi_out | output | LEGS | Upper-switch commands to the gate drivers |
| pwm_lo_out | output | LEGS | Lower-switch commands to the gate drivers |
| pwm_en | output | 1 | PWM release to the stage |
| drv_reset | output | 1 | Fault-latch reset pulse |
| prime_req | output | 1 | Bootstrap priming phase active |
| ramp_req | output | 1 | Ask the speed loop to ramp to zero |
| mains_off_req | output | 1 | Request to disconnect the mains |
| state_code | output | 3 | Current state: 0 idle, 1 wait, 2 reset pulse, 3 prime, 4 run, 5 ramp, 6 off |

## Verification
The bench runs through all eight combinations of the three start conditions. A design that let a partial set through, or that read the undervoltage polarity the wrong way, would enter the reset pulse early.

It measures the reset-pulse and priming widths cycle by cycle, both at first start and after a relay drop. An off-by-one counter or a skipped second pulse shows up as a wrong width or a missing pulse.

It drops the relay feedback in the run state and looks at the outputs before the next edge. A design that waited for the synchronizer would keep switching for two cycles.

It also hammers the off state with inputs to catch an exit that should not happen.

// File: rtl/pstage_pkg.sv
package pstage_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RSTP  = 3'd2,
    ST_PRIME = 3'd3,
    ST_RUN   = 3'd4,
    ST_RAMP  = 3'd5,
    ST_OFF   = 3'd6
  } seq_state_e;

  // cycles for a duration in microseconds, never less than one
  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned per_us);
    return (us * per_us == 0) ? 1 : us * per_us;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // all three start conditions good together
  function automatic logic start_ok(input logic sup, input logic uv, input logic rly);
    return sup & ~uv & rly;
  endfunction

endpackage

// File: rtl/pstage_cond_sync.sv
module pstage_cond_sync #(
  parameter int               STAGES  = 2,
  parameter int               W       = 3,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
          stg[0] <= d;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pstage_phase_timer.sv
module pstage_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic [CW-1:0] cnt,
  output logic          last
);

  assign last = en && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (en)    cnt <= cnt + CW'(1);
  end

  // R4 / R6: an active phase never runs past its limit
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < limit));

endmodule

// File: rtl/pstage_pwm_mask.sv
module pstage_pwm_mask #(
  parameter int LEGS = 3
) (
  input  logic            en,
  input  logic            prime,
  input  logic [LEGS-1:0] hi_in,
  input  logic [LEGS-1:0] lo_in,
  output logic [LEGS-1:0] hi_out,
  output logic [LEGS-1:0] lo_out
);

  generate
    for (genvar g = 0; g < LEGS; g++) begin : g_leg
      assign hi_out[g] = en & ~prime & hi_in[g];
      assign lo_out[g] = en & (prime | lo_in[g]);
    end
  endgenerate

endmodule

// File: rtl/pstage_seq.sv
module pstage_seq
  import pstage_pkg::*;
#(
  parameter int LEGS        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int CYC_PER_US  = 100,
  parameter int RST_US      = 2,
  parameter int PRIME_US    = 50
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            supply_ok,
  input  logic            uv_fb,
  input  logic            relay_fb,
  input  logic            start_req,
  input  logic            stop_req,
  input  logic            speed_zero,
  input  logic [LEGS-1:0] pwm_hi_in,
  input  logic [LEGS-1:0] pwm_lo_in,
  output logic [LEGS-1:0] pwm_hi_out,
  output logic [LEGS-1:0] pwm_lo_out,
  output logic            pwm_en,
  output logic            drv_reset,
  output logic            prime_req,
  output logic            ramp_req,
  output logic            mains_off_req,
  output logic [2:0]      state_code
);

  localparam int unsigned RST_CYC   = us_to_cycles(RST_US, CYC_PER_US);
  localparam int unsigned PRIME_CYC = us_to_cycles(PRIME_US, CYC_PER_US);
  localparam int          CW        = $clog2(max2(RST_CYC, PRIME_CYC) + 1);

  seq_state_e    state, nxt;
  logic [2:0]    cond_s;
  logic          ok_s, relay_s;
  logic          t_en, t_clear, t_last;
  logic [CW-1:0] t_cnt, t_limit;
  logic          phase_live;

  // synchronised start conditions {supply, undervoltage, relay}
  pstage_cond_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({supply_ok, uv_fb, relay_fb}),
    .q(cond_s)
  );
  assign ok_s    = start_ok(cond_s[2], cond_s[1], cond_s[0]);
  assign relay_s = cond_s[0];

  assign t_en    = (state == ST_RSTP) || (state == ST_PRIME);
  assign t_clear = (nxt != state);
  assign t_limit = (state == ST_PRIME) ? CW'(PRIME_CYC) : CW'(RST_CYC);

  pstage_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .en(t_en), .clear(t_clear), .limit(t_limit),
    .cnt(t_cnt), .last(t_last)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start_req) nxt = ST_WAIT;
      ST_WAIT:  if (ok_s) nxt = ST_RSTP;
      ST_RSTP:  if (!ok_s) nxt = ST_WAIT;
                else if (t_last) nxt = ST_PRIME;
      ST_PRIME: if (!relay_s) nxt = ST_WAIT;
                else if (t_last) nxt = ST_RUN;
      ST_RUN:   if (!relay_s) nxt = ST_WAIT;
                else if (stop_req) nxt = ST_RAMP;
      ST_RAMP:  if (!relay_s) nxt = ST_WAIT;
                else if (speed_zero) nxt = ST_OFF;
      ST_OFF:   nxt = ST_OFF;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // raw relay feedback gates PWM without waiting for the synchroniser
  assign phase_live    = (state == ST_PRIME) || (state == ST_RUN) || (state == ST_RAMP);
  assign pwm_en        = phase_live && relay_fb;
  assign drv_reset     = (state == ST_RSTP);
  assign prime_req     = (state == ST_PRIME);
  assign ramp_req      = (state == ST_RAMP);
  assign mains_off_req = (state == ST_OFF);
  assign state_code    = state;

  pstage_pwm_mask #(.LEGS(LEGS)) u_mask (
    .en(pwm_en), .prime(prime_req),
    .hi_in(pwm_hi_in), .lo_in(pwm_lo_in),
    .hi_out(pwm_hi_out), .lo_out(pwm_lo_out)
  );

  // R8: relay feedback low means nothing reaches the drivers
  a_r8_relay_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !relay_fb |-> (!pwm_en && pwm_hi_out == '0 && pwm_lo_out == '0));

  // R3 / R4: a reset pulse starts only from waiting with all conditions good
  a_r4_pulse_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_reset) |-> ($past(state) == ST_WAIT && $past(ok_s)));

  // R6: priming is entered only straight after a reset pulse
  a_r6_prime_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRIME && $past(state) != ST_PRIME) |-> $past(state) == ST_RSTP);

  // R6: priming pattern on the driver outputs
  a_r6_prime_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_req && relay_fb) |-> (pwm_hi_out == '0 && pwm_lo_out == '1));

  // R7 / R9: run is reachable only through priming
  a_r7_run_after_prime: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(state) == ST_PRIME);

  // R5: no PWM in the waiting, pulse, idle or off states
  a_r5_no_early_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_IDLE, ST_WAIT, ST_RSTP, ST_OFF}) |-> (!pwm_en && pwm_hi_out == '0));

  // R11: off is terminal
  a_r11_off_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_OFF |=> state == ST_OFF);

endmodule

// File: tb/tb_pstage_seq.sv
module tb_pstage_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LEGS       = 3;
  localparam int CPU        = 4;
  localparam int RST_US     = 2;
  localparam int PRIME_US   = 50;
  localparam int EXP_RST    = RST_US * CPU;    // 8
  localparam int EXP_PRIME  = PRIME_US * CPU;  // 200

  // {supply_ok, uv_fb, relay_fb, expect_advance}: R3 vectors
  localparam logic [3:0] VEC [8] = '{
    4'b0000, 4'b0010, 4'b0100, 4'b0110,
    4'b1000, 4'b1011, 4'b1100, 4'b1110
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok, uv_fb, relay_fb, start_req, stop_req, speed_zero;
  logic [LEGS-1:0] pwm_hi_in, pwm_lo_in, pwm_hi_out, pwm_lo_out;
  logic pwm_en, drv_reset, prime_req, ramp_req, mains_off_req;
  logic [2:0] state_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  pstage_seq #(.LEGS(LEGS), .SYNC_STAGES(2), .CYC_PER_US(CPU),
               .RST_US(RST_US), .PRIME_US(PRIME_US)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .uv_fb(uv_fb),
    .relay_fb(relay_fb), .start_req(start_req), .stop_req(stop_req),
    .speed_zero(speed_zero), .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
    .pwm_hi_out(pwm_hi_out), .pwm_lo_out(pwm_lo_out), .pwm_en(pwm_en),
    .drv_reset(drv_reset), .prime_req(prime_req), .ramp_req(ramp_req),
    .mains_off_req(mains_off_req), .state_code(state_code)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  bit  saw_pwm = 0;

  always @(negedge clk) if (pwm_en) saw_pwm = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_code(input int code, input int lim, output bit hit);
    hit = 0;
    for (int i = 0; i < lim; i++) begin
      if (state_code == 3'(code)) begin hit = 1; break; end
      @(negedge clk);
    end
  endtask

  // conditions good: measure the pulse and the priming phase, land in run
  task automatic run_up(input string rq_p, input string rq_b);
    bit hit;
    int w;
    bit bad;
    supply_ok = 1; uv_fb = 0; relay_fb = 1;
    pwm_hi_in = '1; pwm_lo_in = '0;
    wait_code(2, 20, hit);
    chk(hit, rq_p, "reset-pulse state reached", state_code, 2);
    w = 0; bad = 0;
    while (drv_reset) begin
      w++;
      if (pwm_en) bad = 1;
      @(negedge clk);
    end
    chk(w == EXP_RST, rq_p, "reset pulse width", w, EXP_RST);
    chk(!bad, rq_p, "pwm_en low during pulse", bad, 0);
    chk(state_code == 3, rq_b, "priming after pulse", state_code, 3);
    w = 0; bad = 0;
    while (prime_req) begin
      w++;
      if (pwm_hi_out != '0 || pwm_lo_out != '1 || !pwm_en) bad = 1;
      @(negedge clk);
    end
    chk(w == EXP_PRIME, rq_b, "priming width", w, EXP_PRIME);
    chk(!bad, rq_b, "priming pattern hi=0 lo=1", bad, 0);
    chk(state_code == 4, rq_b, "run after priming", state_code, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit hit;
    logic [2:0] pats [3];
    supply_ok = 0; uv_fb = 1; relay_fb = 0;
    start_req = 0; stop_req = 0; speed_zero = 0;
    pwm_hi_in = '0; pwm_lo_in = '0;
    nclk(3);
    // R1
    chk(state_code == 0, "R1", "state in reset", state_code, 0);
    chk({pwm_en, drv_reset, prime_req, ramp_req, mains_off_req} == 5'b0,
        "R1", "control outputs in reset",
        {pwm_en, drv_reset, prime_req, ramp_req, mains_off_req}, 0);
    chk(pwm_hi_out == 0 && pwm_lo_out == 0, "R1", "pwm outputs in reset",
        {pwm_hi_out, pwm_lo_out}, 0);
    rst_n = 1;

    // R2: idle ignores good conditions
    supply_ok = 1; uv_fb = 0; relay_fb = 1;
    nclk(6);
    chk(state_code == 0, "R2", "idle holds without start", state_code, 0);
    supply_ok = 0; uv_fb = 1; relay_fb = 0;
    start_req = 1;
    nclk(1);
    start_req = 0;
    chk(state_code == 1, "R2", "start moves to wait", state_code, 1);

    // R3: walk every condition combination
    saw_pwm = 0;
    for (int i = 0; i < 8; i++) begin
      {supply_ok, uv_fb, relay_fb} = VEC[i][3:1];
      nclk(5);
      chk(state_code == (VEC[i][0] ? 3'd2 : 3'd1), "R3", "advance only on all good",
          state_code, VEC[i][0] ? 2 : 1);
      supply_ok = 0; uv_fb = 1; relay_fb = 0;
      wait_code(1, 10, hit);
    end
    chk(!saw_pwm, "R5", "no pwm while qualifying", saw_pwm, 0);

    // R5: abort mid pulse on undervoltage
    saw_pwm = 0;
    supply_ok = 1; uv_fb = 0; relay_fb = 1;
    wait_code(2, 10, hit);
    nclk(2);
    uv_fb = 1;
    wait_code(1, 10, hit);
    chk(hit, "R5", "abort returns to wait", state_code, 1);
    chk(!saw_pwm, "R5", "no pwm after abort", saw_pwm, 0);

    // R4 and R6 on first bring-up
    run_up("R4", "R6");

    // R7: pass-through patterns
    pats[0] = 3'b101; pats[1] = 3'b010; pats[2] = 3'b110;
    for (int i = 0; i < 3; i++) begin
      pwm_hi_in = pats[i]; pwm_lo_in = ~pats[i];
      #1;
      chk(pwm_en && pwm_hi_out == pats[i] && pwm_lo_out == ~pats[i], "R7",
          "run pass-through", {pwm_hi_out, pwm_lo_out}, {pats[i], ~pats[i]});
      nclk(1);
    end

    // R8: relay drop blocks at once
    relay_fb = 0;
    #1;
    chk(!pwm_en && pwm_hi_out == 0 && pwm_lo_out == 0, "R8", "instant inhibit",
        {pwm_en, pwm_hi_out, pwm_lo_out}, 0);
    wait_code(1, 10, hit);
    chk(hit, "R8", "back to wait after relay drop", state_code, 1);

    // R9: fresh pulse and priming before pwm returns
    run_up("R9", "R9");

    // R10: stop starts ramp-down, start ignored
    start_req = 1;
    nclk(2);
    start_req = 0;
    chk(state_code == 4, "R10", "start ignored in run", state_code, 4);
    stop_req = 1;
    nclk(1);
    stop_req = 0;
    pwm_hi_in = 3'b011; pwm_lo_in = 3'b100;
    #1;
    chk(state_code == 5 && ramp_req, "R10", "ramp state", state_code, 5);
    chk(pwm_en && pwm_hi_out == 3'b011 && pwm_lo_out == 3'b100, "R10",
        "pwm passes during ramp", {pwm_hi_out, pwm_lo_out}, 6'b011100);

    // R11: zero speed leads to off, off is sticky
    nclk(1);
    speed_zero = 1;
    nclk(1);
    speed_zero = 0;
    pwm_hi_in = '1; pwm_lo_in = '1;
    #1;
    chk(state_code == 6 && mains_off_req && !pwm_en, "R11", "off state",
        state_code, 6);
    chk(pwm_hi_out == 0 && pwm_lo_out == 0, "R11", "no pwm when off",
        {pwm_hi_out, pwm_lo_out}, 0);
    start_req = 1; relay_fb = 0;
    nclk(4);
    relay_fb = 1; start_req = 0;
    nclk(6);
    chk(state_code == 6, "R11", "off stays off", state_code, 6);

    // R1: reset again from off
    rst_n = 0;
    nclk(2);
    chk(state_code == 0 && !mains_off_req, "R1", "reset leaves off", state_code, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule